// File: doc/BRIEF.md
# Periodic Countdown Tick Timer

This block is a memory-mapped periodic tick timer for a processor subsystem. A down-counter is loaded from a programmable reload register and counts down once per counting tick. When it reaches zero it sets a sticky wrap flag. If interrupts are enabled, it also sends a single-cycle pulse to the interrupt controller. On the next counting tick the counter reloads, so one period is the reload value plus one ticks.

Software uses four 32-bit word registers: control/status, reload value, current value and a fixed calibration word. A control bit selects the count source. The counter can advance on every core clock, or only in cycles where an external reference tick enable is high. The bus bridge, the interrupt controller and clock generation are outside the block. Read data is registered and is valid in the cycle after the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, the control, reload and current-value registers read as zero, and `irq` is low.
- R2: A write to control (offset 0x0) stores only data bits [2:0]: bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = every core clock, 0 = cycles with `ref_tick` high). Other write bits are discarded. A control read returns those three bits, plus the wrap flag at bit 16 and zeros elsewhere.
- R3: The reload register (offset 0x4) keeps the low 24 bits of a write. The current-value register (offset 0x8) reads the 24-bit count with zeros above it.
- R4: When a control write takes the enable bit from 0 to 1, the counter loads the reload value on that write edge. It then decrements once per counting tick.
- R5: While the enable bit is 0, the count holds its value.
- R6: With a nonzero reload value N, the counter passes through N+1 values per period. The first interrupt follows the enabling write by N counting ticks, and later interrupts are N+1 ticks apart.
- R7: When the count steps from 1 to 0, the wrap flag is set. It stays set until a control read, which returns it as 1 and then clears it.
- R8: A wrap raises `irq` for exactly one cycle, and only if the interrupt enable bit is set. With that bit clear, `irq` stays low.
- R9: A write of any data to the current-value register reloads the counter from the reload register and clears the wrap flag.
- R10: A control write that changes the source-select bit reloads the counter.
- R11: With the reference source selected, the counter advances only in cycles where `ref_tick` is high.
- R12: With a reload value of zero, the count stays at zero. The wrap flag is never set and `irq` never rises.
- R13: The calibration register (offset 0xC) always reads the `CALIB_VALUE` parameter. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference count enable, used when the source-select bit is 0 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the word register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Single-cycle interrupt pulse on wrap |

## Verification
The assertions assume the bus never asserts `wr_en` and `rd_en` in the same cycle, and that addresses are word aligned. The interrupt-width and wrap-flag properties also rely on each period being at least two counting ticks long. The stimulus uses one task per access, so only one strobe is ever active. Every address it drives is a multiple of four. Every reload value in the interrupt sweeps is at least 1, and the zero case is run with the interrupt watched for absence only.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_SEL_W = 2;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_SRC   = 2;
  localparam int unsigned BIT_WRAP  = 16;
  localparam int unsigned CTRL_W    = 3;

  typedef struct packed {
    logic src;
    logic ie;
    logic run;
  } ctrl_t;

  function automatic logic [31:0] pack_status(input ctrl_t c, input logic wrap_flag);
    logic [31:0] v;
    v = '0;
    v[BIT_RUN]  = c.run;
    v[BIT_IE]   = c.ie;
    v[BIT_SRC]  = c.src;
    v[BIT_WRAP] = wrap_flag;
    return v;
  endfunction
endpackage

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= ZERO;
    end else if (load) begin
      count_q <= reload_val;
    end else if (step) begin
      if (count_q == ZERO) count_q <= reload_val;
      else                 count_q <= count_q - ONE;
    end
  end

  assign wrap  = step && !load && (count_q == ONE);
  assign count = count_q;
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload_val,
  output logic              load,
  output logic              wrap_flag,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int unsigned PAD_W = 32 - CNT_W;

  reg_sel_e sel;
  logic     wr_ctrl, wr_reload, wr_count, rd_ctrl;
  ctrl_t    ctrl_q, ctrl_new;
  logic [CNT_W-1:0] reload_q;
  logic     flag_q, irq_q;
  logic [31:0] rdata_q, rd_mux;
  logic     unused_bits;

  assign sel       = reg_sel_e'(addr[REG_SEL_W+1:2]);
  assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
  assign wr_reload = wr_en && (sel == SEL_RELOAD);
  assign wr_count  = wr_en && (sel == SEL_COUNT);
  assign rd_ctrl   = rd_en && (sel == SEL_CTRL);
  assign ctrl_new  = ctrl_t'(wdata[CTRL_W-1:0]);

  assign load = wr_count ||
                (wr_ctrl && ((!ctrl_q.run && ctrl_new.run) || (ctrl_q.src != ctrl_new.src)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_new;
      if (wr_reload) reload_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (wr_count) flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (rd_ctrl)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= wrap && ctrl_q.ie;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rd_mux = pack_status(ctrl_q, flag_q);
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
      SEL_COUNT:  rd_mux = {{PAD_W{1'b0}}, count};
      default:    rd_mux = CALIB_VALUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign unused_bits = ^{addr, wdata};

  assign ctrl       = ctrl_q;
  assign reload_val = reload_q;
  assign wrap_flag  = flag_q;
  assign rdata      = rdata_q;
  assign irq        = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val, count;
  logic             load, wrap, wrap_flag, step;

  assign step = ctrl.run && (ctrl.src ? 1'b1 : ref_tick);

  tick_timer_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CALIB_VALUE(CALIB_VALUE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .wrap(wrap), .ctrl(ctrl),
    .reload_val(reload_val), .load(load), .wrap_flag(wrap_flag),
    .rdata(rdata), .irq(irq)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .load(load),
    .reload_val(reload_val), .count(count), .wrap(wrap)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             run,
  input logic             ie,
  input logic             load,
  input logic             wrap_flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val
);
  p_irq_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));

  p_flag_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> wrap_flag);

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));

  p_count_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(reload_val)));

  p_zero_reload_stays_r12: assert property (@(posedge clk) disable iff (rst)
    (reload_val == '0 && count == '0) |=> (count == '0) && !irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .run(ctrl.run), .ie(ctrl.ie),
  .load(load), .wrap_flag(wrap_flag), .count(count), .reload_val(reload_val)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam logic [31:0] CALIB = 32'h0000_2710;

  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        ref_on = 1'b0;
  int          n_chk = 0, n_fail = 0;

  tick_timer #(.ADDR_W(4), .CNT_W(24), .CALIB_VALUE(CALIB)) u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == 2) ? 0 : div + 1;
      ref_tick = ref_on && (div == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < max);
  endtask

  task automatic count_irq(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 reload", d, 32'h0);
    rd(4'h8, d); chk("R1 count", d, 32'h0);

    // R2 control write mask
    wr(4'h0, 32'hFFFF_FFF8); rd(4'h0, d); chk("R2 upper bits dropped", d, 32'h0);
    wr(4'h0, 32'h0000_0006); rd(4'h0, d); chk("R2 low bits kept", d, 32'h6);
    wr(4'h0, 32'h0);

    // R3 reload width
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R3 reload 24 bit", d, 32'h00FF_FFFF);
    wr(4'h8, 32'h0); rd(4'h8, d); chk("R3 count upper zero", d, 32'h00FF_FFFF);

    // R4 enable loads and counts down, R5 hold when disabled
    wr(4'h4, 32'd100);
    wr(4'h0, 32'h5);
    rd(4'h8, d); chk("R4 load on enable", d, 32'd100);
    rd(4'h8, d); chk("R4 decrement", d, 32'd99);
    wr(4'h0, 32'h4);
    rd(4'h8, d); chk("R5 held after disable", d, 32'd97);
    repeat (5) @(negedge clk);
    rd(4'h8, d); chk("R5 still held", d, 32'd97);

    // R6 / R8 period sweep on the core clock
    for (int r = 1; r <= 6; r++) begin
      wr(4'h0, 32'h0);
      wr(4'h4, r);
      wr(4'h0, 32'h7);
      wait_irq(100, n); chk($sformatf("R6 first irq r=%0d", r), n, r);
      wait_irq(100, n); chk($sformatf("R6 gap r=%0d", r), n, r + 1);
      wait_irq(100, n); chk($sformatf("R8 gap2 r=%0d", r), n, r + 1);
    end

    // R7 sticky flag, R8 no irq without enable
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd20);
    wr(4'h0, 32'h5);
    count_irq(25, hits); chk("R8 no irq when disabled", hits, 0);
    rd(4'h0, d); chk("R7 flag set", d, 32'h0001_0005);
    rd(4'h0, d); chk("R7 flag cleared by read", d, 32'h0000_0005);

    // R9 count write reloads and clears the flag
    repeat (20) @(negedge clk);
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h0, d); chk("R9 flag cleared", d, 32'h0000_0005);
    rd(4'h8, d); chk("R9 reloaded", d, 32'd19);

    // R10 source change reloads
    ref_on = 1'b0;
    wr(4'h4, 32'd40);
    repeat (10) @(negedge clk);
    wr(4'h0, 32'h1);
    rd(4'h8, d); chk("R10 reload on source change", d, 32'd40);
    repeat (5) @(negedge clk);
    rd(4'h8, d); chk("R11 no ref tick no step", d, 32'd40);

    // R11 reference tick source
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd3);
    ref_on = 1'b1;
    wr(4'h0, 32'h3);
    wait_irq(200, n);
    wait_irq(200, n); chk("R11 ref gap", n, 12);
    wait_irq(200, n); chk("R11 ref gap2", n, 12);
    ref_on = 1'b0;

    // R12 zero reload
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h7);
    count_irq(40, hits); chk("R12 no irq", hits, 0);
    rd(4'h0, d); chk("R12 no flag", d, 32'h7);
    rd(4'h8, d); chk("R12 count zero", d, 32'h0);

    // R13 calibration
    rd(4'hC, d); chk("R13 calib", d, CALIB);
    wr(4'hC, 32'h1234_5678);
    rd(4'hC, d); chk("R13 calib after write", d, CALIB);

    summary();
    $finish;
  end
endmodule